// File: doc/BRIEF.md
# Divided Phase-Frequency Detector

This block is the digital front end of a clock-recovery loop. It takes a reference clock and a local oscillator clock, both asynchronous to a fast sampling clock, and brings each one into the sampling domain. It detects their rising edges and divides the edge stream of each by the same selectable ratio. The divided edges then drive two edge-set flags. The reference side produces `up` and the oscillator side produces `dn`, and the width of each pulse gives the phase error at the comparison rate. For example, an 11.2896 MHz input compared at a ratio of 16 gives 705.6 kHz comparisons, and a ratio of 8 gives 1.4112 MHz.

Once both flags are set, they stay set together for a programmable number of sampling cycles before a shared clear. This hold ensures that even a zero phase error produces a pulse of nonzero width. A long hold, however, makes the two pulses overlap. The block reports each comparison whose forced overlap was at least as long as the real phase error. It also reports each comparison whose two edges coincided. A lock flag rises after a run of comparisons with small phase error.

Top module: `divided_pfd`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `up`, `dn`, `overlap`, `tie` and `lock` are all 0.
- R2: `div_sel` encodes the ratio N as 0→1, 1→2, 2→4, 3→8, 4→16, and any value from 5 to 7 also gives 16. Exactly one comparison, seen as one rising edge on each of `up` and `dn`, occurs for every N rising edges on each of `ref_in` and `osc_in`.
- R3: `up` is set by a divided reference edge and `dn` by a divided oscillator edge. When the divided edges are k sampling cycles apart, the leading output stays high for k + `hold_dly` + 1 cycles and the trailing output for `hold_dly` + 1 cycles.
- R4: In each comparison, `up` and `dn` are high together for exactly `hold_dly` + 1 cycles and then clear together. A `hold_dly` of 0 therefore gives one common cycle.
- R5: A new `div_sel` value takes effect only when both divider counters sit at their wrap point. A change made mid-count completes the current division under the old ratio.
- R6: `overlap` pulses high for one cycle just after any comparison whose lead k is at most `hold_dly`.
- R7: `tie` pulses high for one cycle just after any comparison whose two divided edges fell in the same cycle (k = 0).
- R8: `lock` rises after 64 consecutive comparisons in which neither output was wider than `hold_dly` + 2 cycles. A single comparison that breaks this bound drops `lock` and restarts the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | 1 | Reference clock, asynchronous |
| osc_in | input | 1 | Local oscillator clock, asynchronous |
| div_sel | input | 3 | Comparison ratio code (R2) |
| hold_dly | input | 4 | Common-hold length in sampling cycles, minus one |
| up | output | 1 | Reference-leads pulse |
| dn | output | 1 | Oscillator-leads pulse |
| overlap | output | 1 | Hold at least as long as phase error (one-cycle pulse) |
| tie | output | 1 | Coincident divided edges (one-cycle pulse) |
| lock | output | 1 | Sustained small phase error |

## Verification
The two divided edges can land in the same sampling cycle, so both flags set together with no lead. At the same time, the hold counter starts and the `tie` and `overlap` reports must both fire. The bench provokes this with offset-zero edge pairs at every ratio and many hold values. It judges the result by accumulated high-cycle counts of `up`, `dn` and their overlap, together with the pulse counts of `tie` and `overlap`. It also makes a ratio change coincide with a counter wrap by changing the selection partway through a division, and checks that the number of comparisons follows the old ratio until the wrap.

// File: rtl/divided_pfd.sv
module divided_pfd #(
  parameter int SEL_W    = 3,
  parameter int DLY_W    = 4,
  parameter int MAX_LOG2 = 4,
  parameter int LEAD_W   = 8,
  parameter int LOCK_RUN = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_in,
  input  logic             osc_in,
  input  logic [SEL_W-1:0] div_sel,
  input  logic [DLY_W-1:0] hold_dly,
  output logic             up,
  output logic             dn,
  output logic             overlap,
  output logic             tie,
  output logic             lock
);
  localparam int CNT_W   = (MAX_LOG2 < 1) ? 1 : MAX_LOG2;
  localparam int LOG_W   = $clog2(MAX_LOG2 + 1);
  localparam int RUN_W   = $clog2(LOCK_RUN + 1);
  localparam int DLY_MAX = (1 << DLY_W) - 1;

  logic [LOG_W-1:0] sel_log, cur_log;
  logic [CNT_W-1:0] last;
  logic [1:0]       raw, tick;
  logic [CNT_W-1:0] cnt [2];

  assign raw     = {osc_in, ref_in};
  assign sel_log = (div_sel > SEL_W'(MAX_LOG2)) ? LOG_W'(MAX_LOG2) : LOG_W'(div_sel);
  assign last    = CNT_W'((1 << cur_log) - 1);

  for (genvar g = 0; g < 2; g++) begin : g_path
    logic [2:0] sh;
    logic       rise;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) sh <= '0;
      else        sh <= {sh[1:0], raw[g]};
    assign rise    = sh[1] & ~sh[2];
    assign tick[g] = rise && (cnt[g] == last);
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)    cnt[g] <= '0;
      else if (rise) cnt[g] <= (cnt[g] == last) ? '0 : cnt[g] + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                                 cur_log <= '0;
    else if (cnt[0] == '0 && cnt[1] == '0)      cur_log <= sel_log;

  logic             up_q, dn_q, both, clr;
  logic [DLY_W-1:0] dcnt;
  logic [LEAD_W-1:0] lead;
  logic [RUN_W-1:0] run;

  assign both = up_q & dn_q;
  assign clr  = both && (dcnt >= hold_dly);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      up_q <= 1'b0;
      dn_q <= 1'b0;
      dcnt <= '0;
    end else if (clr) begin
      up_q <= tick[0];
      dn_q <= tick[1];
      dcnt <= '0;
    end else begin
      up_q <= up_q | tick[0];
      dn_q <= dn_q | tick[1];
      dcnt <= both ? dcnt + 1'b1 : '0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                                  lead <= '0;
    else if (clr)                                lead <= '0;
    else if ((up_q ^ dn_q) && (lead != '1))      lead <= lead + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      overlap <= 1'b0;
      tie     <= 1'b0;
      run     <= '0;
    end else begin
      overlap <= clr && (lead <= LEAD_W'(hold_dly));
      tie     <= clr && (lead == '0);
      if (clr) begin
        if (lead <= LEAD_W'(1)) run <= (run == RUN_W'(LOCK_RUN)) ? run : run + 1'b1;
        else                    run <= '0;
      end
    end

  assign up   = up_q;
  assign dn   = dn_q;
  assign lock = (run == RUN_W'(LOCK_RUN));

  logic [DLY_W:0] both_run;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    both_run <= '0;
    else if (both) both_run <= (both_run == '1) ? both_run : both_run + 1'b1;
    else           both_run <= '0;

  a_r2_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt[0] <= last) && (cnt[1] <= last));
  a_r3_up_from_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(up) |-> $past(tick[0]));
  a_r3_dn_from_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dn) |-> $past(tick[1]));
  a_r4_hold_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (up && dn) |-> (both_run <= (DLY_W+1)'(DLY_MAX)));
  a_r5_ratio_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur_log) |-> $past(cnt[0] == '0 && cnt[1] == '0));
  a_r6_overlap_after_both: assert property (@(posedge clk) disable iff (!rst_n)
    overlap |-> $past(up && dn));
  a_r7_tie_implies_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    tie |-> overlap);
  a_r8_lock_drop_at_compare: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock) |-> $past(up && dn));
endmodule

// File: tb/tb_divided_pfd.sv
`timescale 1ns/1ps
module tb_divided_pfd;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_in = 1'b0, osc_in = 1'b0;
  logic [2:0] div_sel = 3'd0;
  logic [3:0] hold_dly = 4'd0;
  logic up, dn, overlap, tie, lock;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  divided_pfd dut (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .osc_in(osc_in),
    .div_sel(div_sel), .hold_dly(hold_dly),
    .up(up), .dn(dn), .overlap(overlap), .tie(tie), .lock(lock)
  );

  int c_up, c_dn, c_both, c_rise, c_ovl, c_tie;
  logic up_d = 1'b0;
  always @(negedge clk) begin
    if (up)         c_up++;
    if (dn)         c_dn++;
    if (up && dn)   c_both++;
    if (up && !up_d) c_rise++;
    if (overlap)    c_ovl++;
    if (tie)        c_tie++;
    up_d = up;
  end

  task automatic clear_counts();
    c_up = 0; c_dn = 0; c_both = 0; c_rise = 0; c_ovl = 0; c_tie = 0;
  endtask

  task automatic chk(string tag, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic pair(int off);
    int r0, o0;
    r0 = (off < 0) ? -off : 0;
    o0 = (off > 0) ? off : 0;
    for (int c = 0; c < 48; c++) begin
      @(negedge clk);
      ref_in = (c >= r0) && (c < r0 + 3);
      osc_in = (c >= o0) && (c < o0 + 3);
    end
  endtask

  function automatic int ratio(int sel);
    return 1 << ((sel > 4) ? 4 : sel);
  endfunction

  function automatic int iabs(int v);
    return (v < 0) ? -v : v;
  endfunction

  task automatic scen(int sel, int d, int off, int m);
    int n, lead;
    div_sel = sel[2:0];
    hold_dly = d[3:0];
    repeat (3) @(negedge clk);
    clear_counts();
    n = ratio(sel);
    for (int i = 0; i < n * m; i++) pair(off);
    lead = iabs(off);
    chk($sformatf("R2 comparisons sel=%0d", sel), c_rise, m);
    chk($sformatf("R3 up width off=%0d d=%0d", off, d), c_up, m * (((off > 0) ? off : 0) + d + 1));
    chk($sformatf("R3 dn width off=%0d d=%0d", off, d), c_dn, m * (((off < 0) ? -off : 0) + d + 1));
    chk($sformatf("R4 common hold d=%0d", d), c_both, m * (d + 1));
    chk($sformatf("R6 overlap off=%0d d=%0d", off, d), c_ovl, (lead <= d) ? m : 0);
    chk($sformatf("R7 tie off=%0d", off), c_tie, (off == 0) ? m : 0);
  endtask

  initial begin
    void'($urandom(32'hC0FFEE));
    repeat (3) @(negedge clk);
    chk("R1 reset up", up, 0);
    chk("R1 reset dn", dn, 0);
    chk("R1 reset overlap|tie|lock", overlap | tie | lock, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", up | dn | overlap | tie | lock, 0);

    scen(0, 0, 0, 3);
    scen(0, 0, 4, 2);
    scen(1, 3, -2, 2);
    scen(2, 5, 7, 1);
    scen(3, 15, 0, 1);
    scen(4, 2, -12, 1);
    scen(6, 1, 1, 1);

    // R5: change ratio partway through a division by 4
    div_sel = 3'd2; hold_dly = 4'd1;
    repeat (3) @(negedge clk);
    clear_counts();
    pair(0); pair(0);
    chk("R5 mid-count no compare", c_rise, 0);
    div_sel = 3'd0;
    clear_counts();
    for (int i = 0; i < 4; i++) pair(0);
    chk("R5 old ratio kept until wrap", c_rise, 3);

    // R8: lock run
    div_sel = 3'd0; hold_dly = 4'd2;
    repeat (3) @(negedge clk);
    pair(6);
    chk("R8 no lock after bad compare", lock, 0);
    for (int i = 0; i < 63; i++) pair((i % 2 == 0) ? 1 : -1);
    chk("R8 no lock at 63", lock, 0);
    pair(0);
    chk("R8 lock at 64", lock, 1);
    pair(1);
    chk("R8 lock holds on good compare", lock, 1);
    pair(3);
    chk("R8 lock drops on wide pulse", lock, 0);

    for (int it = 0; it < 20; it++) begin
      int s, d, o, m;
      s = $urandom_range(0, 7);
      d = $urandom_range(0, 15);
      o = $urandom_range(0, 24) - 12;
      m = (s >= 4) ? 1 : $urandom_range(1, 3);
      scen(s, d, o, m);
    end

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #780000;
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired got 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule